// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Controller

This block sits beside the transmit and receive FIFOs of an SPI controller and keeps track of how full each one is. It follows single-cycle push and pop strobes, keeps an occupancy count for each FIFO, and turns those counts and the illegal accesses it sees into a status vector, a raw interrupt vector, a masked interrupt vector, one combined interrupt line and two DMA request lines. The FIFO memories and the serial engine are outside the block. Only the strobes and an engine-busy signal come in.

Firmware programs four watermarks through a small write port: a transmit threshold, a receive threshold, a transmit DMA level and a receive DMA level. It also writes an interrupt mask and a DMA enable pair. It reads everything back through a combinational read port. Sticky error interrupts are cleared by writing the clear register. That register's bit layout differs from the interrupt vector, and it has a bit that clears every sticky source at once.

The strobes are plain event pulses with no back-pressure. A push into a full FIFO is dropped and flagged. A pop from an empty FIFO leaves the count unchanged and is flagged where the vector has a bit for it. Control, status and register pins are plain signals.

Top module: `spi_fifo_monitor`

## Requirements
- R1: Each FIFO count moves by +1 for an accepted push and by -1 for an accepted pop. A push is accepted only when the FIFO is below DEPTH, and a pop only when the FIFO is non-empty. A push and a pop accepted in the same cycle leave the count unchanged. The transmit count reads at address 7 and the receive count at address 8.
- R2: The status vector reads at address 9 and has these bits: bit0 engine busy, bit1 transmit full, bit2 transmit empty, bit3 receive empty, bit4 receive full.
- R3: Interrupt bit1 (transmit overflow) is set in the cycle after a push into a full transmit FIFO and stays set until it is cleared.
- R4: Interrupt bit2 (receive underflow) is set in the cycle after a pop from an empty receive FIFO and stays set until it is cleared.
- R5: Interrupt bit3 (receive overflow) is set in the cycle after a push into a full receive FIFO and stays set until it is cleared.
- R6: Interrupt bit0 is high while the transmit count is less than or equal to the transmit threshold (address 0).
- R7: Interrupt bit4 is high while the receive count is greater than the receive threshold (address 1).
- R8: A write to address 6 clears sticky bits as follows: bit0 clears all of them, bit1 clears receive underflow, bit2 clears receive overflow, bit3 clears transmit overflow. Address 6 reads as zero.
- R9: When a set event and a clear of the same sticky bit fall in the same cycle, the bit stays set.
- R10: The masked vector (address 11) is the raw vector (address 10) ANDed with the mask (address 4). The irq output is high when any masked bit is high.
- R11: The DMA enable register is at address 5, with bit0 for receive and bit1 for transmit. The transmit request is high while it is enabled and the transmit count is less than or equal to the transmit DMA level (address 2). The receive request is high while it is enabled and the receive count is greater than the receive DMA level (address 3).
- R12: Reset clears both counts, every watermark, the mask, the DMA enables and every sticky bit. A write to an address above 6 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Firmware writes a word into the transmit FIFO |
| tx_pop | input | 1 | Engine takes a word from the transmit FIFO |
| rx_push | input | 1 | Engine writes a word into the receive FIFO |
| rx_pop | input | 1 | Firmware takes a word from the receive FIFO |
| engine_busy | input | 1 | Serial engine is mid-transfer |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | REG_W | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | REG_W | Register read data, combinational |
| status | output | 5 | Status vector |
| irq_raw | output | 5 | Unmasked interrupt vector |
| irq_masked | output | 5 | Masked interrupt vector |
| irq | output | 1 | Combined interrupt |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The bench drives both FIFOs to full and pushes once more. A design that saturated the count but forgot the flag, or let the count wrap, would show a wrong level or a missing overflow bit. It issues clears together with new overflow events, so a design that let the clear win would drop the bit. It walks each single-source clear through the remapped clear layout, so a design that reused the interrupt bit positions would clear the wrong error. It pushes and pops an empty receive FIFO in the same cycle to check that the underflow is flagged while the push still counts. It also moves each threshold and DMA level across the current count to catch an off-by-one between "at or below" and "above".

// File: rtl/fifo_mon_pkg.sv
package fifo_mon_pkg;

  localparam int ADDR_W = 4;
  localparam int VEC_W  = 5;

  // status vector bit positions
  localparam int ST_BUSY    = 0;
  localparam int ST_TXFULL  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_RXEMPTY = 3;
  localparam int ST_RXFULL  = 4;

  // interrupt vector bit positions
  localparam int IV_TXLOW  = 0;
  localparam int IV_TXOVF  = 1;
  localparam int IV_RXUDF  = 2;
  localparam int IV_RXOVF  = 3;
  localparam int IV_RXHIGH = 4;

  // clear register bit positions
  localparam int CL_ALL   = 0;
  localparam int CL_RXUDF = 1;
  localparam int CL_RXOVF = 2;
  localparam int CL_TXOVF = 3;

  // dma enable bit positions
  localparam int DE_RX = 0;
  localparam int DE_TX = 1;

  // sticky bank slots
  localparam int SK_TXOVF = 0;
  localparam int SK_RXUDF = 1;
  localparam int SK_RXOVF = 2;
  localparam int SK_N     = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_TX_THR  = 4'd0,
    RA_RX_THR  = 4'd1,
    RA_TX_DMA  = 4'd2,
    RA_RX_DMA  = 4'd3,
    RA_MASK    = 4'd4,
    RA_DMA_EN  = 4'd5,
    RA_CLEAR   = 4'd6,
    RA_TX_LVL  = 4'd7,
    RA_RX_LVL  = 4'd8,
    RA_STATUS  = 4'd9,
    RA_RAW     = 4'd10,
    RA_MASKED  = 4'd11
  } reg_addr_e;

endpackage

// File: rtl/fifo_level_tracker.sv
module fifo_level_tracker #(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             push_drop,
  output logic             pop_drop
);

  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

  logic acc_push, acc_pop;

  assign full      = (level == LVL_MAX);
  assign empty     = (level == '0);
  assign push_drop = push & full;
  assign pop_drop  = pop & empty;
  assign acc_push  = push & ~full;
  assign acc_pop   = pop & ~empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
    end else if (acc_push != acc_pop) begin
      level <= acc_push ? level + 1'b1 : level - 1'b1;
    end
  end

endmodule

// File: rtl/fifo_mon_regs.sv
module fifo_mon_regs
  import fifo_mon_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int LVL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [LVL_W-1:0]  tx_thr,
  output logic [LVL_W-1:0]  rx_thr,
  output logic [LVL_W-1:0]  tx_dma_lvl,
  output logic [LVL_W-1:0]  rx_dma_lvl,
  output logic [VEC_W-1:0]  mask,
  output logic [1:0]        dma_en,
  output logic [3:0]        clr_bits
);

  logic             wdata_hi_unused;
  logic [LVL_W-1:0] wlvl;

  assign wlvl            = cfg_wdata[LVL_W-1:0];
  assign wdata_hi_unused = ^cfg_wdata[REG_W-1:LVL_W];

  // clear register is a pulse: nothing stored
  assign clr_bits = (cfg_we && cfg_addr == RA_CLEAR) ? cfg_wdata[3:0] : 4'b0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr     <= '0;
      rx_thr     <= '0;
      tx_dma_lvl <= '0;
      rx_dma_lvl <= '0;
      mask       <= '0;
      dma_en     <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        RA_TX_THR: tx_thr     <= wlvl;
        RA_RX_THR: rx_thr     <= wlvl;
        RA_TX_DMA: tx_dma_lvl <= wlvl;
        RA_RX_DMA: rx_dma_lvl <= wlvl;
        RA_MASK:   mask       <= cfg_wdata[VEC_W-1:0];
        RA_DMA_EN: dma_en     <= cfg_wdata[1:0];
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/sticky_err_bank.sv
module sticky_err_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flags
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
      end else begin
        // a new event in the same cycle overrides the clear
        flags[i] <= set_evt[i] | (flags[i] & ~clr_req[i]);
      end
    end
  end

endmodule

// File: rtl/irq_dma_gen.sv
module irq_dma_gen
  import fifo_mon_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic [LVL_W-1:0] tx_lvl,
  input  logic [LVL_W-1:0] rx_lvl,
  input  logic [LVL_W-1:0] tx_thr,
  input  logic [LVL_W-1:0] rx_thr,
  input  logic [LVL_W-1:0] tx_dma_lvl,
  input  logic [LVL_W-1:0] rx_dma_lvl,
  input  logic [SK_N-1:0]  sticky,
  input  logic [VEC_W-1:0] mask,
  input  logic [1:0]       dma_en,
  output logic [VEC_W-1:0] raw,
  output logic [VEC_W-1:0] masked,
  output logic             irq,
  output logic             dma_tx_req,
  output logic             dma_rx_req
);

  always_comb begin
    raw            = '0;
    raw[IV_TXLOW]  = (tx_lvl <= tx_thr);
    raw[IV_TXOVF]  = sticky[SK_TXOVF];
    raw[IV_RXUDF]  = sticky[SK_RXUDF];
    raw[IV_RXOVF]  = sticky[SK_RXOVF];
    raw[IV_RXHIGH] = (rx_lvl > rx_thr);
  end

  assign masked     = raw & mask;
  assign irq        = |masked;
  assign dma_tx_req = dma_en[DE_TX] & (tx_lvl <= tx_dma_lvl);
  assign dma_rx_req = dma_en[DE_RX] & (rx_lvl > rx_dma_lvl);

endmodule

// File: rtl/spi_fifo_monitor.sv
module spi_fifo_monitor
  import fifo_mon_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int REG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_push,
  input  logic              tx_pop,
  input  logic              rx_push,
  input  logic              rx_pop,
  input  logic              engine_busy,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic [VEC_W-1:0]  status,
  output logic [VEC_W-1:0]  irq_raw,
  output logic [VEC_W-1:0]  irq_masked,
  output logic              irq,
  output logic              dma_tx_req,
  output logic              dma_rx_req
);

  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int CH_TX = 0;
  localparam int CH_RX = 1;

  logic [1:0]       ch_push, ch_pop, ch_full, ch_empty, ch_pdrop, ch_odrop;
  logic [LVL_W-1:0] ch_lvl [2];

  assign ch_push = {rx_push, tx_push};
  assign ch_pop  = {rx_pop, tx_pop};

  for (genvar c = 0; c < 2; c++) begin : g_ch
    fifo_level_tracker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (ch_push[c]),
      .pop       (ch_pop[c]),
      .level     (ch_lvl[c]),
      .full      (ch_full[c]),
      .empty     (ch_empty[c]),
      .push_drop (ch_pdrop[c]),
      .pop_drop  (ch_odrop[c])
    );
  end

  logic tx_underrun_unused;
  assign tx_underrun_unused = ch_odrop[CH_TX];

  logic [LVL_W-1:0] tx_thr, rx_thr, tx_dma_lvl, rx_dma_lvl;
  logic [VEC_W-1:0] mask;
  logic [1:0]       dma_en;
  logic [3:0]       clr_bits;

  fifo_mon_regs #(.REG_W(REG_W), .LVL_W(LVL_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .tx_thr     (tx_thr),
    .rx_thr     (rx_thr),
    .tx_dma_lvl (tx_dma_lvl),
    .rx_dma_lvl (rx_dma_lvl),
    .mask       (mask),
    .dma_en     (dma_en),
    .clr_bits   (clr_bits)
  );

  // remap clear layout onto sticky slots
  logic [SK_N-1:0] sk_set, sk_clr, sticky;

  always_comb begin
    sk_set           = '0;
    sk_set[SK_TXOVF] = ch_pdrop[CH_TX];
    sk_set[SK_RXUDF] = ch_odrop[CH_RX];
    sk_set[SK_RXOVF] = ch_pdrop[CH_RX];
    sk_clr           = '0;
    sk_clr[SK_TXOVF] = clr_bits[CL_ALL] | clr_bits[CL_TXOVF];
    sk_clr[SK_RXUDF] = clr_bits[CL_ALL] | clr_bits[CL_RXUDF];
    sk_clr[SK_RXOVF] = clr_bits[CL_ALL] | clr_bits[CL_RXOVF];
  end

  sticky_err_bank #(.N(SK_N)) u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (sk_set),
    .clr_req (sk_clr),
    .flags   (sticky)
  );

  irq_dma_gen #(.LVL_W(LVL_W)) u_gen (
    .tx_lvl     (ch_lvl[CH_TX]),
    .rx_lvl     (ch_lvl[CH_RX]),
    .tx_thr     (tx_thr),
    .rx_thr     (rx_thr),
    .tx_dma_lvl (tx_dma_lvl),
    .rx_dma_lvl (rx_dma_lvl),
    .sticky     (sticky),
    .mask       (mask),
    .dma_en     (dma_en),
    .raw        (irq_raw),
    .masked     (irq_masked),
    .irq        (irq),
    .dma_tx_req (dma_tx_req),
    .dma_rx_req (dma_rx_req)
  );

  always_comb begin
    status             = '0;
    status[ST_BUSY]    = engine_busy;
    status[ST_TXFULL]  = ch_full[CH_TX];
    status[ST_TXEMPTY] = ch_empty[CH_TX];
    status[ST_RXEMPTY] = ch_empty[CH_RX];
    status[ST_RXFULL]  = ch_full[CH_RX];
  end

  always_comb begin
    case (rd_addr)
      RA_TX_THR: rd_data = REG_W'(tx_thr);
      RA_RX_THR: rd_data = REG_W'(rx_thr);
      RA_TX_DMA: rd_data = REG_W'(tx_dma_lvl);
      RA_RX_DMA: rd_data = REG_W'(rx_dma_lvl);
      RA_MASK:   rd_data = REG_W'(mask);
      RA_DMA_EN: rd_data = REG_W'(dma_en);
      RA_TX_LVL: rd_data = REG_W'(ch_lvl[CH_TX]);
      RA_RX_LVL: rd_data = REG_W'(ch_lvl[CH_RX]);
      RA_STATUS: rd_data = REG_W'(status);
      RA_RAW:    rd_data = REG_W'(irq_raw);
      RA_MASKED: rd_data = REG_W'(irq_masked);
      default:   rd_data = '0;
    endcase
  end

endmodule

// File: rtl/fifo_mon_checker.sv
module fifo_mon_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_push,
  input logic       rx_push,
  input logic       rx_pop,
  input logic       cfg_we,
  input logic [3:0] cfg_addr,
  input logic [3:0] clr_low,
  input logic [4:0] status,
  input logic [4:0] irq_raw,
  input logic [4:0] irq_masked
);

  logic clr_tx_hit;
  assign clr_tx_hit = cfg_we && (cfg_addr == 4'd6) && (clr_low[0] || clr_low[3]);

  // R3 and R9: overflow is flagged even if a clear lands in the same cycle
  assert_tx_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && status[1]) |=> irq_raw[1]);

  assert_tx_ovf_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_raw[1] && !clr_tx_hit) |=> irq_raw[1]);

  assert_rx_udf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && status[3]) |=> irq_raw[2]);

  assert_rx_ovf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && status[4]) |=> irq_raw[3]);

  assert_full_empty_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[1] && status[2]) && !(status[3] && status[4]));

  assert_tx_full_needs_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(tx_push));

  assert_masked_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_masked & ~irq_raw) == 5'b0);

endmodule

bind spi_fifo_monitor fifo_mon_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_push    (tx_push),
  .rx_push    (rx_push),
  .rx_pop     (rx_pop),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .clr_low    (cfg_wdata[3:0]),
  .status     (status),
  .irq_raw    (irq_raw),
  .irq_masked (irq_masked)
);

// File: tb/tb_spi_fifo_monitor.sv
`timescale 1ns/1ps
module tb_spi_fifo_monitor;

  localparam int DEPTH = 4;
  localparam int REG_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, engine_busy = 0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [4:0]  status, irq_raw, irq_masked;
  logic        irq, dma_tx_req, dma_rx_req;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  spi_fifo_monitor #(.DEPTH(DEPTH), .REG_W(REG_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
    .engine_busy(engine_busy),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .status(status), .irq_raw(irq_raw), .irq_masked(irq_masked), .irq(irq),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  typedef struct packed {
    logic [3:0] strb;   // {tx_push, tx_pop, rx_push, rx_pop}
    logic       busy;
    logic       we;
    logic [3:0] addr;
    logic [7:0] wd;
    logic [4:0] st;
    logic [4:0] raw;
    logic [4:0] msk;
    logic       irq;
    logic [1:0] dma;    // {tx, rx}
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{4'b0000,1'b0,1'b1,4'd4,8'h1F,5'h0C,5'h01,5'h01,1'b1,2'b00}, // R10 mask all
    '{4'b0000,1'b0,1'b1,4'd0,8'h02,5'h0C,5'h01,5'h01,1'b1,2'b00}, // R6 tx thr 2
    '{4'b1000,1'b0,1'b0,4'd0,8'h00,5'h08,5'h01,5'h01,1'b1,2'b00}, // R1 tx 1
    '{4'b1000,1'b0,1'b0,4'd0,8'h00,5'h08,5'h01,5'h01,1'b1,2'b00}, // R6 tx 2 at thr
    '{4'b1000,1'b0,1'b0,4'd0,8'h00,5'h08,5'h00,5'h00,1'b0,2'b00}, // R6 tx 3 above
    '{4'b1000,1'b0,1'b0,4'd0,8'h00,5'h0A,5'h00,5'h00,1'b0,2'b00}, // R2 tx full
    '{4'b1000,1'b0,1'b0,4'd0,8'h00,5'h0A,5'h02,5'h02,1'b1,2'b00}, // R3 overflow
    '{4'b1100,1'b0,1'b0,4'd0,8'h00,5'h08,5'h02,5'h02,1'b1,2'b00}, // R3 push+pop full
    '{4'b0000,1'b0,1'b1,4'd6,8'h08,5'h08,5'h00,5'h00,1'b0,2'b00}, // R8 clear tx ovf
    '{4'b0001,1'b0,1'b0,4'd0,8'h00,5'h08,5'h04,5'h04,1'b1,2'b00}, // R4 underflow
    '{4'b0010,1'b0,1'b0,4'd0,8'h00,5'h00,5'h14,5'h14,1'b1,2'b00}, // R7 rx 1 > 0
    '{4'b0000,1'b0,1'b1,4'd1,8'h02,5'h00,5'h04,5'h04,1'b1,2'b00}, // R7 rx thr 2
    '{4'b0010,1'b0,1'b0,4'd0,8'h00,5'h00,5'h04,5'h04,1'b1,2'b00}, // R7 rx 2 at thr
    '{4'b0010,1'b0,1'b0,4'd0,8'h00,5'h00,5'h14,5'h14,1'b1,2'b00}, // R7 rx 3
    '{4'b0010,1'b0,1'b0,4'd0,8'h00,5'h10,5'h14,5'h14,1'b1,2'b00}, // R2 rx full
    '{4'b0010,1'b0,1'b0,4'd0,8'h00,5'h10,5'h1C,5'h1C,1'b1,2'b00}, // R5 overflow
    '{4'b0001,1'b0,1'b1,4'd6,8'h02,5'h00,5'h18,5'h18,1'b1,2'b00}, // R8 clear udf
    '{4'b0010,1'b0,1'b0,4'd0,8'h00,5'h10,5'h18,5'h18,1'b1,2'b00}, // R1 rx 4
    '{4'b0010,1'b0,1'b1,4'd6,8'h04,5'h10,5'h18,5'h18,1'b1,2'b00}, // R9 set wins
    '{4'b0000,1'b0,1'b1,4'd6,8'h01,5'h10,5'h10,5'h10,1'b1,2'b00}, // R8 clear all
    '{4'b0000,1'b0,1'b1,4'd4,8'h01,5'h10,5'h10,5'h00,1'b0,2'b00}, // R10 mask narrow
    '{4'b0000,1'b0,1'b1,4'd5,8'h03,5'h10,5'h10,5'h00,1'b0,2'b01}, // R11 enable
    '{4'b0000,1'b0,1'b1,4'd2,8'h03,5'h10,5'h10,5'h00,1'b0,2'b11}, // R11 tx lvl 3
    '{4'b0000,1'b0,1'b1,4'd3,8'h04,5'h10,5'h10,5'h00,1'b0,2'b10}, // R11 rx lvl 4
    '{4'b0000,1'b1,1'b0,4'd0,8'h00,5'h11,5'h10,5'h00,1'b0,2'b10}  // R2 busy
  };

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
    rd_addr = a;
    #1;
    chk(req, $sformatf("read addr %0d", a), rd_data, exp);
  endtask

  task automatic drive_idle();
    {tx_push, tx_pop, rx_push, rx_pop} = 4'b0000;
    cfg_we = 1'b0;
    cfg_addr = '0;
    cfg_wdata = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12", "status after reset", 16'(status), 16'h0C);
    chk("R12", "raw after reset", 16'(irq_raw), 16'h01);
    chk("R12", "irq after reset", 16'(irq), 16'h0);

    for (int i = 0; i < NV; i++) begin
      {tx_push, tx_pop, rx_push, rx_pop} = TBL[i].strb;
      engine_busy = TBL[i].busy;
      cfg_we      = TBL[i].we;
      cfg_addr    = TBL[i].addr;
      cfg_wdata   = 16'(TBL[i].wd);
      @(negedge clk);
      drive_idle();
      chk("R2",  $sformatf("row %0d status", i), 16'(status), 16'(TBL[i].st));
      chk("R3-5", $sformatf("row %0d raw", i), 16'(irq_raw), 16'(TBL[i].raw));
      chk("R10", $sformatf("row %0d masked", i), 16'(irq_masked), 16'(TBL[i].msk));
      chk("R10", $sformatf("row %0d irq", i), 16'(irq), 16'(TBL[i].irq));
      chk("R11", $sformatf("row %0d dma", i), 16'({dma_tx_req, dma_rx_req}), 16'(TBL[i].dma));
    end

    // R1 levels and register readback
    rd_chk("R1", 4'd7, 16'd3);
    rd_chk("R1", 4'd8, 16'd4);
    rd_chk("R6", 4'd0, 16'd2);
    rd_chk("R7", 4'd1, 16'd2);
    rd_chk("R11", 4'd2, 16'd3);
    rd_chk("R11", 4'd3, 16'd4);
    rd_chk("R11", 4'd5, 16'd3);
    rd_chk("R10", 4'd4, 16'h01);
    rd_chk("R2", 4'd9, 16'h11);
    rd_chk("R10", 4'd10, 16'h10);
    rd_chk("R10", 4'd11, 16'h00);
    rd_chk("R8", 4'd6, 16'h00);

    // R12 reset mid-run
    @(negedge clk);
    engine_busy = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "status after second reset", 16'(status), 16'h0C);
    chk("R12", "raw after second reset", 16'(irq_raw), 16'h01);
    chk("R12", "dma after second reset", 16'({dma_tx_req, dma_rx_req}), 16'h0);
    rd_chk("R12", 4'd0, 16'd0);
    rd_chk("R12", 4'd7, 16'd0);

    // R12 write above address 6 changes nothing
    cfg_we = 1'b1; cfg_addr = 4'd12; cfg_wdata = 16'hFFFF;
    @(negedge clk);
    drive_idle();
    rd_chk("R12", 4'd4, 16'h00);
    rd_chk("R12", 4'd5, 16'h00);
    chk("R12", "irq after ignored write", 16'(irq), 16'h0);

    // R4 push and pop together on empty rx: underflow flagged, push counted
    rx_push = 1'b1; rx_pop = 1'b1;
    @(negedge clk);
    drive_idle();
    chk("R4", "underflow on empty pop", 16'(irq_raw[2]), 16'h1);
    rd_chk("R1", 4'd8, 16'd1);

    // R1 tx pop on empty tx leaves count at zero and no error bits
    tx_pop = 1'b1;
    @(negedge clk);
    drive_idle();
    rd_chk("R1", 4'd7, 16'd0);
    chk("R3", "no tx overflow from empty pop", 16'(irq_raw[1]), 16'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule